// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits in a receive path and decides, for each incoming frame, whether to keep or drop it on the basis of its 48-bit destination address. The six address octets arrive one per enabled clock, first octet first, and a start strobe marks the first octet. The block accepts a frame when any of these holds: the address equals the programmed station address; it is the all-ones broadcast address; it is the fixed MAC-control multicast 01:80:C2:00:00:01; it is a multicast whose hash bit is set in a 256-bit table while hash filtering is on; or promiscuous mode is on.

The multicast hash is the top byte of the bit-reflected CRC-32 of the six octets. That CRC starts from all ones, uses the reflected polynomial 0xEDB88320 with the octets entering least significant bit first, and has no final inversion. The CRC is built up one octet per cycle as the address arrives. The decision therefore costs a single register stage after the sixth octet. A small write-only register file holds the hash table, the station address and the two mode bits.

Top module: `eth_dest_filter`

## Requirements
- R1: The decision (dec_valid high for exactly one cycle, with dec_accept) appears in the cycle after the sixth address octet is taken. Octets with rx_byte_valid high but no start, arriving before a start or after the sixth octet, are ignored. Idle cycles between octets are allowed.
- R2: A start strobe (rx_byte_start with rx_byte_valid) always begins a new address with that octet as octet 0, abandoning any partial one.
- R3: The station address is held at register addresses 16, 17 and 18. Address 16 holds octets 4 and 5, address 17 holds octets 2 and 3, and address 18 holds octets 0 and 1, with the lower-numbered octet in bits 15:8. An exact match is accepted.
- R4: A unicast address (bit 0 of octet 0 clear) that misses the station address is rejected unless promiscuous mode is on.
- R5: Register address 19 bit 0 is promiscuous mode; when it is set, every frame is accepted.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R7: The MAC-control address 01:80:C2:00:00:01 is always accepted.
- R8: With hash enable (register address 19 bit 1) set, a multicast is accepted when bit h[3:0] of hash word h[7:4] is set. The hash words sit at register addresses 0 to 15, and h is bits 31:24 of the reflected CRC described above. A multicast whose bit is clear is rejected.
- R9: With hash enable clear and promiscuous mode off, a multicast other than broadcast, the MAC-control address or the station address is rejected whatever the table holds.
- R10: A hash table of all ones accepts every multicast while hash enable is set.
- R11: After reset dec_valid is low and every register is zero, so a multicast is rejected.
- R12: Writes to register addresses 20 to 31 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | CFG_AW (5) | Register write address |
| cfg_wr_data | input | 16 | Register write data |
| rx_byte_valid | input | 1 | An address octet is present |
| rx_byte_start | input | 1 | The present octet is octet 0 |
| rx_byte | input | 8 | Address octet |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted when dec_valid is high |

## Verification
The assertions assume that register writes do not coincide with the cycle of the sixth octet in a way that matters. They read the mode and the hit flags from the same cycle as that octet, so a write landing on the same edge has no effect until later. The assertions also rely on at most one octet being offered per cycle. The stimulus keeps register writes and address streams in separate phases. It does add partial addresses, restarts, idle gaps and trailing octets to reach the ignore and restart cases, and a behavioural model compares dec_valid and dec_accept on every cycle.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int WORD_W     = 16;
  localparam int HASH_WORDS = 16;
  localparam int STN_WORDS  = 3;
  localparam int CRC_W      = 32;
  localparam int HASH_BITS  = $clog2(HASH_WORDS * WORD_W);
  localparam int MAC_W      = 8 * ADDR_BYTES;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

  localparam int REG_HASH_BASE = 0;
  localparam int REG_STN_BASE  = REG_HASH_BASE + HASH_WORDS;
  localparam int REG_MODE      = REG_STN_BASE + STN_WORDS;

  localparam logic [CRC_W-1:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED   = '1;
  localparam logic [MAC_W-1:0] MAC_CTRL_DA = 48'h0180C2000001;

  typedef logic [7:0]       octet_t;
  typedef logic [MAC_W-1:0] mac_t;

  typedef struct packed {
    logic hash_en;
    logic promisc;
  } rx_mode_t;

  typedef struct packed {
    logic station;
    logic mac_ctrl;
    logic bcast;
    logic mcast;
    logic hash;
  } hit_t;

  // One octet through the reflected CRC-32, low bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                input octet_t d);
    logic [CRC_W-1:0] c;
    c = crc ^ {{(CRC_W-8){1'b0}}, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [HASH_BITS-1:0] hash_idx(input logic [CRC_W-1:0] crc);
    return crc[CRC_W-1 -: HASH_BITS];
  endfunction
endpackage

// File: rtl/addr_filter_regs.sv
module addr_filter_regs
  import eth_filt_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [HASH_WORDS*WORD_W-1:0]   hash_tbl,
  output mac_t                           station,
  output rx_mode_t                       mode
);
  for (genvar g = 0; g < HASH_WORDS; g++) begin : g_hash
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (wr_en && wr_addr == AW'(REG_HASH_BASE + g)) word_q <= wr_data;
    end
    assign hash_tbl[g*WORD_W +: WORD_W] = word_q;
  end

  for (genvar g = 0; g < STN_WORDS; g++) begin : g_stn
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (wr_en && wr_addr == AW'(REG_STN_BASE + g)) word_q <= wr_data;
    end
    assign station[g*WORD_W +: WORD_W] = word_q;
  end

  rx_mode_t mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_en && wr_addr == AW'(REG_MODE)) mode_q <= rx_mode_t'(wr_data[1:0]);
  end
  assign mode = mode_q;
endmodule

// File: rtl/addr_filter_collect.sv
module addr_filter_collect
  import eth_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  octet_t           in_data,
  output logic             last_byte,
  output mac_t             addr_full,
  output logic [CRC_W-1:0] crc_full
);
  localparam int KEEP = ADDR_BYTES - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic             mid_byte;

  assign mid_byte  = in_valid && !in_start && cnt_q != '0 &&
                     cnt_q < CNT_W'(ADDR_BYTES);
  assign last_byte = mid_byte && cnt_q == CNT_W'(KEEP);
  assign crc_full  = crc_step(crc_q, in_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
    end else if (in_valid && in_start) begin
      cnt_q <= CNT_W'(1);
      crc_q <= crc_step(CRC_SEED, in_data);
    end else if (mid_byte) begin
      cnt_q <= cnt_q + CNT_W'(1);
      crc_q <= crc_full;
    end
  end

  for (genvar i = 0; i < KEEP; i++) begin : g_oct
    octet_t oct_q;
    logic   take;
    if (i == 0) begin : g_first
      assign take = in_valid && in_start;
    end else begin : g_rest
      assign take = mid_byte && cnt_q == CNT_W'(i);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oct_q <= '0;
      else if (take) oct_q <= in_data;
    end
    assign addr_full[MAC_W-1-8*i -: 8] = oct_q;
  end
  assign addr_full[7:0] = in_data;
endmodule

// File: rtl/addr_filter_match.sv
module addr_filter_match
  import eth_filt_pkg::*;
(
  input  mac_t                         addr,
  input  logic [CRC_W-1:0]             crc,
  input  logic [HASH_WORDS*WORD_W-1:0] hash_tbl,
  input  mac_t                         station,
  input  rx_mode_t                     mode,
  output hit_t                         hits,
  output logic                         accept
);
  always_comb begin
    hits.station  = (addr == station);
    hits.mac_ctrl = (addr == MAC_CTRL_DA);
    hits.bcast    = &addr;
    hits.mcast    = addr[MAC_W-8];
    hits.hash     = hash_tbl[hash_idx(crc)];
    accept = mode.promisc | hits.station | hits.mac_ctrl | hits.bcast |
             (hits.mcast & mode.hash_en & hits.hash);
  end
endmodule

// File: rtl/eth_dest_filter.sv
module eth_dest_filter
  import eth_filt_pkg::*;
#(
  parameter int CFG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [15:0]       cfg_wr_data,
  input  logic              rx_byte_valid,
  input  logic              rx_byte_start,
  input  logic [7:0]        rx_byte,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic [HASH_WORDS*WORD_W-1:0] hash_tbl;
  mac_t                         station;
  rx_mode_t                     mode;
  logic                         last_byte;
  mac_t                         addr_full;
  logic [CRC_W-1:0]             crc_full;
  hit_t                         hits;
  logic                         accept_now;

  addr_filter_regs #(.AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .hash_tbl(hash_tbl), .station(station), .mode(mode)
  );

  addr_filter_collect u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_byte_valid), .in_start(rx_byte_start),
    .in_data(rx_byte), .last_byte(last_byte), .addr_full(addr_full),
    .crc_full(crc_full)
  );

  addr_filter_match u_match (
    .addr(addr_full), .crc(crc_full), .hash_tbl(hash_tbl), .station(station),
    .mode(mode), .hits(hits), .accept(accept_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last_byte;
      dec_accept <= last_byte && accept_now;
    end
  end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic last_byte,
  input logic dec_valid,
  input logic dec_accept,
  input logic promisc,
  input logic hash_en,
  input logic hit_station,
  input logic hit_ctrl,
  input logic hit_bcast,
  input logic hit_mcast,
  input logic hit_hash
);
  // R1
  decision_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_valid);
  // R1
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(last_byte));
  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  // R3
  station_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && hit_station |=> dec_accept);
  // R4
  unicast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && !hit_mcast && !hit_station && !promisc |=> !dec_accept);
  // R5
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && promisc |=> dec_accept);
  // R6
  bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && hit_bcast |=> dec_accept);
  // R7
  ctrl_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && hit_ctrl |=> dec_accept);
  // R8
  hash_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && hit_mcast && hash_en && hit_hash |=> dec_accept);
  // R9
  hash_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && hit_mcast && !hash_en && !promisc && !hit_bcast &&
    !hit_ctrl && !hit_station |=> !dec_accept);
endmodule

bind eth_dest_filter addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .last_byte(last_byte), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .promisc(mode.promisc), .hash_en(mode.hash_en),
  .hit_station(hits.station), .hit_ctrl(hits.mac_ctrl), .hit_bcast(hits.bcast),
  .hit_mcast(hits.mcast), .hit_hash(hits.hash)
);

// File: tb/tb_eth_dest_filter.sv
`timescale 1ns/1ps
module tb_eth_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic        rx_byte_valid = 1'b0;
  logic        rx_byte_start = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_valid, dec_accept;

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  eth_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .rx_byte_valid(rx_byte_valid),
    .rx_byte_start(rx_byte_start), .rx_byte(rx_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // Bit-serial reflected CRC, octets first to last, each low bit first.
  function automatic int unsigned ref_crc(input logic [47:0] a);
    int unsigned c = 32'hFFFFFFFF;
    for (int j = 0; j < 6; j++) begin
      logic [7:0] b = a[47-8*j -: 8];
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ b[i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  function automatic int ref_hash(input logic [47:0] a);
    return int'(ref_crc(a) >> 24);
  endfunction

  // Behavioural reference model
  logic [15:0] m_hash [16];
  logic [15:0] m_stn [3];
  bit m_promisc, m_hash_en;
  logic [7:0] m_q [$];
  bit m_valid, m_acc;

  function automatic bit model_accept(input logic [47:0] a);
    int h = ref_hash(a);
    bit hashed = m_hash[h / 16][h % 16];
    if (m_promisc) return 1'b1;
    if (a == {m_stn[2], m_stn[1], m_stn[0]}) return 1'b1;
    if (a == 48'h0180C2000001) return 1'b1;
    if (a == 48'hFFFFFFFFFFFF) return 1'b1;
    return a[40] && m_hash_en && hashed;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_hash[i]) m_hash[i] = '0;
      foreach (m_stn[i]) m_stn[i] = '0;
      m_promisc = 0; m_hash_en = 0; m_valid = 0; m_acc = 0;
      m_q.delete();
    end else begin
      m_valid = 0; m_acc = 0;
      if (rx_byte_valid) begin
        if (rx_byte_start) begin
          m_q.delete();
          m_q.push_back(rx_byte);
        end else if (m_q.size() > 0 && m_q.size() < 6) begin
          m_q.push_back(rx_byte);
          if (m_q.size() == 6) begin
            m_valid = 1;
            m_acc = model_accept({m_q[0], m_q[1], m_q[2], m_q[3], m_q[4], m_q[5]});
          end
        end
      end
      if (cfg_wr_en) begin
        if (cfg_wr_addr < 16) m_hash[cfg_wr_addr] = cfg_wr_data;
        else if (cfg_wr_addr < 19) m_stn[cfg_wr_addr - 16] = cfg_wr_data;
        else if (cfg_wr_addr == 19) begin
          m_promisc = cfg_wr_data[0];
          m_hash_en = cfg_wr_data[1];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      total++;
      if (dec_valid !== m_valid || (m_valid && dec_accept !== m_acc)) begin
        bad++;
        $display("FAIL R1 R8 per-cycle model: valid=%0b accept=%0b expected valid=%0b accept=%0b",
                 dec_valid, dec_accept, m_valid, m_acc);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_addr = 5'(a); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic set_station(input logic [47:0] a);
    wr(16, a[15:0]); wr(17, a[31:16]); wr(18, a[47:32]);
  endtask

  // Sends six octets; gap inserts an idle cycle after each octet.
  task automatic send(input logic [47:0] a, input bit exp, input string tag,
                      input bit gap = 0);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      rx_byte_valid = 1; rx_byte_start = (j == 0); rx_byte = a[47-8*j -: 8];
      if (gap && j < 5) begin
        @(negedge clk);
        rx_byte_valid = 0; rx_byte_start = 0;
      end
    end
    @(negedge clk);
    rx_byte_valid = 0; rx_byte_start = 0;
    check({tag, " valid"}, 32'(dec_valid), 32'd1);
    check({tag, " accept"}, 32'(dec_accept), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] ma, mb, mc, stn;
    int ha, hb;
    bit found;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_on = 1;

    // R11 reset state
    check("R11 valid after reset", 32'(dec_valid), 0);
    ma = 48'h01005E000001;
    send(ma, 0, "R11 multicast after reset");

    // R3 / R4 station address
    stn = 48'h021122334455;
    set_station(stn);
    send(stn, 1, "R3 station exact");
    send(48'h021122334454, 0, "R4 unicast miss");
    send(48'h445522330211, 0, "R3 word order");
    send(stn, 1, "R1 gapped octets", 1);

    // R6 / R7 fixed addresses
    send(48'hFFFFFFFFFFFF, 1, "R6 broadcast");
    send(48'h0180C2000001, 1, "R7 mac control");

    // R5 promiscuous
    wr(19, 16'h0001);
    send(48'h0A0B0C0D0E0F, 1, "R5 promisc unicast");
    send(48'h0300AA000001, 1, "R5 promisc multicast");
    wr(19, 16'h0000);

    // R8 hash lookup
    ha = ref_hash(ma);
    wr(ha / 16, 16'(1 << (ha % 16)));
    wr(19, 16'h0002);
    send(ma, 1, "R8 hash bit set");
    found = 0; mb = ma;
    for (int k = 0; k < 256 && !found; k++) begin
      mc = {40'h01005E0001, 8'(k)};
      if (ref_hash(mc) != ha) begin mb = mc; found = 1; end
    end
    hb = ref_hash(mb);
    check("R8 distinct hash found", 32'(found), 1);
    send(mb, 0, "R8 hash bit clear");
    found = 0; mc = ma;
    for (int k = 0; k < 4096 && !found; k++) begin
      logic [47:0] t = {32'h01005E00, 16'(k)};
      if (ref_hash(t) / 16 == ha / 16 && ref_hash(t) != ha) begin mc = t; found = 1; end
    end
    if (found) send(mc, 0, "R8 same word other bit");

    // R9 hash disabled
    wr(19, 16'h0000);
    send(ma, 0, "R9 hash disabled");

    // R10 all-ones table
    for (int w = 0; w < 16; w++) wr(w, 16'hFFFF);
    wr(19, 16'h0002);
    send(ma, 1, "R10 all ones a");
    send(mb, 1, "R10 all ones b");
    send(48'h3300000000FB, 1, "R10 all ones c");
    send(48'h0A0B0C0D0E0F, 0, "R10 unicast still rejected");

    // R12 unmapped addresses
    for (int w = 0; w < 16; w++) wr(w, 16'h0000);
    for (int a = 20; a < 32; a++) wr(a, 16'hFFFF);
    send(ma, 0, "R12 table untouched a");
    send(mb, 0, "R12 table untouched b");
    send(stn, 1, "R12 station untouched");
    send(48'h0A0B0C0D0E0F, 0, "R12 mode untouched");

    // R2 restart mid-address
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      rx_byte_valid = 1; rx_byte_start = (j == 0); rx_byte = 8'h55;
    end
    send(48'hFFFFFFFFFFFF, 1, "R2 restart");

    // R1 trailing octets after the sixth are ignored
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      rx_byte_valid = 1; rx_byte_start = 0; rx_byte = 8'hFF;
      check("R1 trailing octet", 32'(dec_valid), (j == 0) ? 32'd0 : 32'd0);
    end
    @(negedge clk);
    rx_byte_valid = 0;
    check("R1 no decision from trailing", 32'(dec_valid), 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule